// File: doc/BRIEF.md
# Safeload Parameter Update Controller

This block lets a host change filter coefficients while audio is playing without corrupting the stream. The host writes up to five address/data pairs over the control port into shadow staging slots. Nothing reaches a RAM until a commit has been requested and the processing core signals that its RAM access for the current frame has ended. The controller then drains every staged slot, lowest slot first, at one RAM write per clock. Five slots plus one closing cycle fit easily within the idle part of one audio frame, so a whole biquad section changes between two consecutive frames.

Each staged address is decoded when it is drained. Addresses 0 to 1023 go to the 1024-entry, 28-bit coefficient RAM, using the lower 28 bits of the 40-bit staged value. Addresses 0x0A00 to 0x0A3F go to the 64-entry, 34-bit ramping-target RAM, using the lower 34 bits and the offset from 0x0A00. This path is the only way to write the ramping-target RAM. Any other staged address is dropped and raises a sticky error, so program memory and control registers can never be reached through this path.

Top module: `safeload_ctrl`

## Requirements
- R1: After reset, both RAM write enables, busy_o, done_o, range_err_o and wr_err_o are low, and no slot is staged.
- R2: A write to 0x0A40+i (i = 0..4) stores the 40-bit value in slot i and marks slot i staged. A write to 0x0A45+i stores bits 15:0 as the target address of slot i and does not mark the slot staged. Writes to any other control address leave every slot unchanged.
- R3: A commit request raised while idle_i is low starts nothing. It stays pending, and the drain starts at the clock edge where idle_i is high.
- R4: A drain issues exactly one RAM write per clock for each staged slot, in ascending slot index regardless of the order in which the slots were written. The first write is visible two clocks after the starting edge.
- R5: A staged address in 0..1023 produces coef_we_o with coef_addr_o equal to the address and coef_data_o equal to bits 27:0 of the staged value.
- R6: A staged address in 0x0A00..0x0A3F produces ramp_we_o with ramp_addr_o equal to the address minus 0x0A00 and ramp_data_o equal to bits 33:0 of the staged value.
- R7: A staged address outside both ranges (for example 1024, 0x09FF or 0x0A40) produces no RAM write in its cycle and sets range_err_o, which stays set until reset.
- R8: busy_o is high from the clock after the starting edge through the last write cycle. done_o is high for exactly one clock, the clock after the last write, and busy_o is low in that clock.
- R9: A drained slot is no longer staged. A commit with no staged slot produces no RAM write, one busy clock and one done pulse.
- R10: A write to any staging address while busy_o is high is ignored and sets wr_err_o, which stays set until reset.
- R11: coef_we_o and ramp_we_o are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control-port register write strobe |
| wr_addr_i | input | 16 | Control-port register address |
| wr_data_i | input | 40 | Assembled write bytes, right-aligned |
| commit_i | input | 1 | Request to drain the staged slots |
| idle_i | input | 1 | Core is not using the target RAMs this cycle |
| coef_we_o | output | 1 | Coefficient RAM write enable |
| coef_addr_o | output | 10 | Coefficient RAM write address |
| coef_data_o | output | 28 | Coefficient RAM write data |
| ramp_we_o | output | 1 | Ramping-target RAM write enable |
| ramp_addr_o | output | 6 | Ramping-target RAM write address |
| ramp_data_o | output | 34 | Ramping-target RAM write data |
| busy_o | output | 1 | Drain in progress |
| done_o | output | 1 | One-clock pulse after a drain completes |
| range_err_o | output | 1 | Sticky: a staged address hit neither RAM |
| wr_err_o | output | 1 | Sticky: staging write arrived during a drain |

## Verification
The drain is exercised with all 31 non-empty staged-slot masks. Slots are written in descending order, and each slot's address is chosen from the mask and index to alternate between the two RAMs, so any error in slot order, skipping, routing or data truncation shows up as a wrong write in a known cycle. Commit is sometimes raised together with idle and sometimes several cycles before it, which separates immediate starts from pending ones. Boundary addresses at the edges of both windows, and just outside them, show whether the range decode is off by one. A staging write injected during a drain, followed by an empty commit, shows whether a slot can be re-armed while it is locked.

// File: rtl/safeload_pkg.sv
`timescale 1ns/1ps
package safeload_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_COEF, TGT_RAMP} tgt_e;
endpackage

// File: rtl/safeload_regs.sv
`timescale 1ns/1ps
module safeload_regs #(
  parameter int NUM_SLOTS = 5,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 40,
  parameter int DATA_BASE = 'h0A40,
  parameter int ADDR_BASE = 'h0A45,
  localparam int IDXW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    wr_addr_i,
  input  logic [DATA_W-1:0]                    wr_data_i,
  input  logic                                 lock_i,
  input  logic                                 clr_en_i,
  input  logic [IDXW-1:0]                      clr_idx_i,
  output logic [NUM_SLOTS-1:0]                 valid_o,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]     slot_addr_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]     slot_data_o,
  output logic                                 blocked_o
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(ADDR_BASE + NUM_SLOTS);

  logic [NUM_SLOTS-1:0] valid_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_data, hit_addr;
    assign hit_data = wr_en_i && !lock_i && (wr_addr_i == ADDR_W'(DATA_BASE + g));
    assign hit_addr = wr_en_i && !lock_i && (wr_addr_i == ADDR_W'(ADDR_BASE + g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g]     <= 1'b0;
        slot_data_o[g] <= '0;
        slot_addr_o[g] <= '0;
      end else begin
        if (hit_data) begin
          slot_data_o[g] <= wr_data_i;
          valid_q[g]     <= 1'b1;
        end else if (clr_en_i && clr_idx_i == IDXW'(g)) begin
          valid_q[g]     <= 1'b0;
        end
        if (hit_addr) slot_addr_o[g] <= wr_data_i[ADDR_W-1:0];
      end
    end
  end

  assign valid_o   = valid_q;
  assign blocked_o = wr_en_i && lock_i && (wr_addr_i >= WIN_LO) && (wr_addr_i < WIN_HI);

  // R10
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

// File: rtl/safeload_seq.sv
`timescale 1ns/1ps
module safeload_seq #(
  parameter int NUM_SLOTS = 5,
  localparam int IDXW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic                 idle_i,
  input  logic [NUM_SLOTS-1:0] valid_i,
  output logic                 busy_o,
  output logic                 issue_o,
  output logic [IDXW-1:0]      issue_idx_o,
  output logic                 done_o
);
  logic pending_q, busy_q, done_q, start, any_valid;

  always_comb begin
    issue_idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (valid_i[i]) issue_idx_o = IDXW'(i);
  end

  assign any_valid = |valid_i;
  assign start     = (pending_q || commit_i) && idle_i && !busy_q;
  assign issue_o   = busy_q && any_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (start)         pending_q <= 1'b0;
      else if (commit_i) pending_q <= 1'b1;
      if (start)                      busy_q <= 1'b1;
      else if (busy_q && !any_valid)  busy_q <= 1'b0;
      done_q <= busy_q && !any_valid;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R3
  start_in_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(idle_i));
endmodule

// File: rtl/safeload_route.sv
`timescale 1ns/1ps
module safeload_route
  import safeload_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 40,
  parameter int COEF_DEPTH = 1024,
  parameter int COEF_W     = 28,
  parameter int RAMP_BASE  = 'h0A00,
  parameter int RAMP_DEPTH = 64,
  parameter int RAMP_W     = 34,
  localparam int COEF_AW   = $clog2(COEF_DEPTH),
  localparam int RAMP_AW   = $clog2(RAMP_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               coef_we_o,
  output logic [COEF_AW-1:0] coef_addr_o,
  output logic [COEF_W-1:0]  coef_data_o,
  output logic               ramp_we_o,
  output logic [RAMP_AW-1:0] ramp_addr_o,
  output logic [RAMP_W-1:0]  ramp_data_o,
  output logic               range_err_o
);
  localparam logic [ADDR_W-1:0] COEF_LIM = ADDR_W'(COEF_DEPTH);
  localparam logic [ADDR_W-1:0] RAMP_LO  = ADDR_W'(RAMP_BASE);
  localparam logic [ADDR_W-1:0] RAMP_HI  = ADDR_W'(RAMP_BASE + RAMP_DEPTH);

  tgt_e              tgt;
  logic [ADDR_W-1:0] ramp_off;
  logic              unused_bits;

  assign ramp_off    = addr_i - RAMP_LO;
  assign unused_bits = ^{ramp_off[ADDR_W-1:RAMP_AW], data_i[DATA_W-1:RAMP_W]};

  always_comb begin
    if (addr_i < COEF_LIM)                          tgt = TGT_COEF;
    else if (addr_i >= RAMP_LO && addr_i < RAMP_HI) tgt = TGT_RAMP;
    else                                            tgt = TGT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_we_o   <= 1'b0;
      coef_addr_o <= '0;
      coef_data_o <= '0;
      ramp_we_o   <= 1'b0;
      ramp_addr_o <= '0;
      ramp_data_o <= '0;
      range_err_o <= 1'b0;
    end else begin
      coef_we_o <= issue_i && (tgt == TGT_COEF);
      ramp_we_o <= issue_i && (tgt == TGT_RAMP);
      if (issue_i && tgt == TGT_COEF) begin
        coef_addr_o <= addr_i[COEF_AW-1:0];
        coef_data_o <= data_i[COEF_W-1:0];
      end
      if (issue_i && tgt == TGT_RAMP) begin
        ramp_addr_o <= ramp_off[RAMP_AW-1:0];
        ramp_data_o <= data_i[RAMP_W-1:0];
      end
      if (issue_i && tgt == TGT_NONE) range_err_o <= 1'b1;
    end
  end

  // R11
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coef_we_o && ramp_we_o));
  // R7
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(range_err_o) |-> (!coef_we_o && !ramp_we_o));
endmodule

// File: rtl/safeload_ctrl.sv
`timescale 1ns/1ps
module safeload_ctrl #(
  parameter int NUM_SLOTS  = 5,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 40,
  parameter int DATA_BASE  = 'h0A40,
  parameter int ADDR_BASE  = 'h0A45,
  parameter int COEF_DEPTH = 1024,
  parameter int COEF_W     = 28,
  parameter int RAMP_BASE  = 'h0A00,
  parameter int RAMP_DEPTH = 64,
  parameter int RAMP_W     = 34,
  localparam int COEF_AW   = $clog2(COEF_DEPTH),
  localparam int RAMP_AW   = $clog2(RAMP_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               commit_i,
  input  logic               idle_i,
  output logic               coef_we_o,
  output logic [COEF_AW-1:0] coef_addr_o,
  output logic [COEF_W-1:0]  coef_data_o,
  output logic               ramp_we_o,
  output logic [RAMP_AW-1:0] ramp_addr_o,
  output logic [RAMP_W-1:0]  ramp_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               range_err_o,
  output logic               wr_err_o
);
  localparam int IDXW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0]             valid;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data;
  logic                             blocked, issue, busy;
  logic [IDXW-1:0]                  issue_idx;

  safeload_regs #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DATA_BASE(DATA_BASE), .ADDR_BASE(ADDR_BASE)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .lock_i(busy), .clr_en_i(issue), .clr_idx_i(issue_idx),
    .valid_o(valid), .slot_addr_o(slot_addr), .slot_data_o(slot_data),
    .blocked_o(blocked)
  );

  safeload_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk_i, .rst_ni, .commit_i, .idle_i, .valid_i(valid),
    .busy_o(busy), .issue_o(issue), .issue_idx_o(issue_idx), .done_o
  );

  safeload_route #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_DEPTH(COEF_DEPTH), .COEF_W(COEF_W),
    .RAMP_BASE(RAMP_BASE), .RAMP_DEPTH(RAMP_DEPTH), .RAMP_W(RAMP_W)
  ) u_route (
    .clk_i, .rst_ni, .issue_i(issue),
    .addr_i(slot_addr[issue_idx]), .data_i(slot_data[issue_idx]),
    .coef_we_o, .coef_addr_o, .coef_data_o,
    .ramp_we_o, .ramp_addr_o, .ramp_data_o, .range_err_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_err_o <= 1'b0;
    else if (blocked) wr_err_o <= 1'b1;
  end

  assign busy_o = busy;

  // R8
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_o);
  // R4
  write_in_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_we_o || ramp_we_o) |-> $past(busy));
endmodule

// File: tb/safeload_ctrl_bench.sv
`timescale 1ns/1ps
module safeload_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [39:0] wr_data = '0;
  logic        commit = 1'b0, idle = 1'b0;
  logic        coef_we, ramp_we, busy, done, range_err, wr_err;
  logic [9:0]  coef_addr;
  logic [27:0] coef_data;
  logic [5:0]  ramp_addr;
  logic [33:0] ramp_data;

  int errs = 0, checks = 0;
  int n_exp;
  int e_kind [5];
  int e_addr [5];
  logic [39:0] e_data [5];

  always #2.5 clk = ~clk;

  safeload_ctrl u_safeload_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .commit_i(commit), .idle_i(idle),
    .coef_we_o(coef_we), .coef_addr_o(coef_addr), .coef_data_o(coef_data),
    .ramp_we_o(ramp_we), .ramp_addr_o(ramp_addr), .ramp_data_o(ramp_data),
    .busy_o(busy), .done_o(done), .range_err_o(range_err), .wr_err_o(wr_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; commit = 1'b0; idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [39:0] d);
    wr_en = 1'b1; wr_addr = 16'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stage(input int slot, input int a, input logic [39:0] d);
    wr('h0A45 + slot, 40'(a));
    wr('h0A40 + slot, d);
  endtask

  function automatic logic [39:0] mk_data(input int m, input int i);
    return 40'h13579BDF02 ^ (40'(m) << 17) ^ (40'(i) << 3) ^ (40'(m * i) << 30);
  endfunction

  function automatic int mk_addr(input int m, input int i);
    if (((m + i) % 2) == 1) return 2560 + ((m * 5 + i) % 64);
    return (m * 37 + i * 101) % 1024;
  endfunction

  task automatic add_exp(input int a, input logic [39:0] d);
    e_addr[n_exp] = a;
    e_data[n_exp] = d;
    if (a < 1024) e_kind[n_exp] = 1;
    else if (a >= 2560 && a < 2624) e_kind[n_exp] = 2;
    else e_kind[n_exp] = 0;
    n_exp++;
  endtask

  task automatic do_flush(input bit split, input bit inject);
    if (split) begin
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      for (int w = 0; w < 3; w++) begin
        @(negedge clk);
        chk("R3 busy while waiting for idle", 64'(busy), 64'd0);
        chk("R3 no write while waiting", 64'({coef_we, ramp_we}), 64'd0);
      end
      idle = 1'b1;
      @(negedge clk);
      idle = 1'b0;
    end else begin
      commit = 1'b1; idle = 1'b1;
      @(negedge clk);
      commit = 1'b0; idle = 1'b0;
    end
    chk("R8 busy after start", 64'(busy), 64'd1);
    chk("R4 no write before first slot", 64'({coef_we, ramp_we}), 64'd0);
    if (inject) begin
      wr_en = 1'b1; wr_addr = 16'h0A40; wr_data = 40'hFFFFFFFFFF;
    end
    for (int k = 0; k < n_exp; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      chk("R8 busy during drain", 64'(busy), 64'd1);
      chk("R8 no early done", 64'(done), 64'd0);
      chk("R11 write enables", 64'({coef_we, ramp_we}),
          64'(e_kind[k] == 1 ? 2 : (e_kind[k] == 2 ? 1 : 0)));
      if (e_kind[k] == 1) begin
        chk("R5 coef addr", 64'(coef_addr), 64'(e_addr[k]));
        chk("R5 coef data", 64'(coef_data), 64'(e_data[k][27:0]));
      end else if (e_kind[k] == 2) begin
        chk("R6 ramp addr", 64'(ramp_addr), 64'(e_addr[k] - 2560));
        chk("R6 ramp data", 64'(ramp_data), 64'(e_data[k][33:0]));
      end else begin
        chk("R7 no write for bad addr", 64'({coef_we, ramp_we}), 64'd0);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 done pulse", 64'(done), 64'd1);
    chk("R8 busy low with done", 64'(busy), 64'd0);
    chk("R4 no extra write", 64'({coef_we, ramp_we}), 64'd0);
    @(negedge clk);
    chk("R8 done one clock", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 coef_we", 64'(coef_we), 64'd0);
    chk("R1 ramp_we", 64'(ramp_we), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 errors", 64'({range_err, wr_err}), 64'd0);
    n_exp = 0;
    do_flush(1'b0, 1'b0); // R1 nothing staged, R9 empty drain

    // R2 non-staging writes and address-only writes stage nothing
    wr('h0A4A, 40'h1234);
    wr('h0A3F, 40'h5678);
    wr('h0A47, 40'd5);
    n_exp = 0;
    do_flush(1'b0, 1'b0);
    chk("R2 no error from ignored writes", 64'({range_err, wr_err}), 64'd0);

    // R4 R5 R6 sweep of all masks, slots written high to low
    for (int m = 1; m < 32; m++) begin
      for (int i = 4; i >= 0; i--)
        if (m[i]) stage(i, mk_addr(m, i), mk_data(m, i));
      n_exp = 0;
      for (int i = 0; i < 5; i++)
        if (m[i]) add_exp(mk_addr(m, i), mk_data(m, i));
      do_flush((m % 3) == 0, 1'b0);
      chk("R7 no range error in sweep", 64'(range_err), 64'd0);
    end
    n_exp = 0;
    do_flush(1'b1, 1'b0); // R9 slots cleared after full drain

    // R7 window boundaries
    do_reset();
    n_exp = 0;
    stage(0, 1023, 40'hAA12345678); add_exp(1023, 40'hAA12345678);
    stage(1, 'h0A00, 40'h55CAFEBABE); add_exp('h0A00, 40'h55CAFEBABE);
    stage(2, 1024, 40'h0101010101);   add_exp(1024, 40'h0101010101);
    stage(3, 'h0A3F, 40'hFFFFFFFFFF); add_exp('h0A3F, 40'hFFFFFFFFFF);
    stage(4, 'h09FF, 40'h0800000);    add_exp('h09FF, 40'h0800000);
    do_flush(1'b0, 1'b0);
    chk("R7 sticky range error", 64'(range_err), 64'd1);
    chk("R10 no write error", 64'(wr_err), 64'd0);
    n_exp = 0;
    stage(0, 'h0A40, 40'h1); add_exp('h0A40, 40'h1);
    stage(1, 0, 40'h0800000); add_exp(0, 40'h0800000);
    do_flush(1'b1, 1'b0);
    chk("R7 range error stays set", 64'(range_err), 64'd1);

    // R10 staging write during drain is dropped
    do_reset();
    n_exp = 0;
    stage(0, 5, 40'h0000000111); add_exp(5, 40'h0000000111);
    stage(1, 6, 40'h0000000222); add_exp(6, 40'h0000000222);
    do_flush(1'b0, 1'b1);
    chk("R10 sticky write error", 64'(wr_err), 64'd1);
    n_exp = 0;
    do_flush(1'b0, 1'b0);
    chk("R10 range error untouched", 64'(range_err), 64'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule